// File: doc/BRIEF.md
# Five-Stage Pipelined 32-bit Integer Core

This block is a small 32-bit in-order processor core that executes a load/store/ALU/branch subset of a classic three-format instruction set. Each instruction passes through five stages: fetch, decode with register read, execute, memory access and register write-back. Pipeline registers separate the stages. Control is decoded once, in the decode stage. It is then carried forward in groups beside the data, and each group is dropped once its stage has used it. Every instruction class uses the same five-stage template, so the register file needs only one write port, and that port is used in the fifth stage.

The core holds a word-addressed instruction memory and a word-addressed data memory. A preload port writes both memories, normally while reset is held. The core has no forwarding and no hazard detection, and it does not cancel instructions fetched after a taken branch. The program is therefore responsible for spacing. A value written by one instruction is visible to an instruction fetched three or more slots later. The two instructions that follow a branch always execute. Observation ports show the program counter, the register-file write slot and the data-memory store slot. Reset is asserted asynchronously and released through a two-flop synchroniser, so the first fetch happens two clock edges after the reset input rises.

Top module: `pipe5_core`

## Requirements
- R1: While reset is applied, and in the first cycle after the internal reset releases, the program counter reads 0. No register write and no store is reported in the first four cycles after release.
- R2: With no taken branch, the program counter advances by 4 on every clock. The instruction at byte address pc is read from word pc[MEM_AW+1:2].
- R3: An R-type instruction (opcode 0x00) with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or or 0x2A signed set-less-than applies the operation to rs (bits [25:21]) and rt (bits [20:16]). It reports a write of the result to rd (bits [15:11]) on the write slot exactly four cycles after it is fetched.
- R4: A load (opcode 0x23) reads the data-memory word at rs plus the sign-extended bits [15:0]. It reports a write of that word to rt four cycles after fetch.
- R5: A store (opcode 0x2B) shows the address rs+sext(imm) and the data rt on the store slot three cycles after fetch. It writes that word into data memory and reports no register write.
- R6: A branch-if-equal (opcode 0x04) whose operands rs and rt match sets the pc to fetch_pc+4+(sext(imm)<<2) three cycles after fetch. The two instructions fetched after the branch still execute. A branch whose operands differ does not change the pc sequence. A branch never writes a register.
- R7: Register 0 reads as zero, and an instruction that targets register 0 reports no write.
- R8: An instruction fetched exactly three cycles after a writer reads the value being written in that same cycle.
- R9: An unknown opcode, an unknown R-type funct and the all-zero word do nothing: no register write and no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| pl_imem_we | input | 1 | Preload write strobe for instruction memory |
| pl_dmem_we | input | 1 | Preload write strobe for data memory (takes priority over a core store) |
| pl_addr | input | MEM_AW | Word index for a preload write |
| pl_data | input | 32 | Preload write data |
| pc_o | output | 32 | Current fetch program counter |
| rf_we_o | output | 1 | Register-file write slot valid (write-back stage) |
| rf_waddr_o | output | 5 | Destination register of the write |
| rf_wdata_o | output | 32 | Value being written |
| st_we_o | output | 1 | Store slot valid (memory stage) |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Data being stored |

## Verification
The bench builds the core with its default MEM_AW of 6, which gives 64-word memories. At this depth a whole test program fits, with its NOP padding, its skipped branch slots and a closing self-loop. A store with offset -4 from register 0 also wraps to the top word of data memory. This lets the bench check that the full 32-bit address appears on the store port while only the low index bits select a word. A later load reads back a stored word through a spacing of exactly three slots, which exercises the same-cycle register bypass.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    branch;
    alu_op_e alu_op;
  } ex_ctrl_t;

  typedef struct packed {
    logic mem_read;
    logic mem_write;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifid_t;

  typedef struct packed {
    ex_ctrl_t          ex;
    mem_ctrl_t         mem;
    wb_ctrl_t          wb;
    logic [XLEN-1:0]   pc4;
    logic [XLEN-1:0]   opa;
    logic [XLEN-1:0]   opb;
    logic [XLEN-1:0]   imm;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
  } idex_t;

  typedef struct packed {
    mem_ctrl_t         mem;
    wb_ctrl_t          wb;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   stdata;
    logic [REG_AW-1:0] dst;
  } exmem_t;

  typedef struct packed {
    wb_ctrl_t          wb;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   mdata;
    logic [REG_AW-1:0] dst;
  } memwb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ex_ctrl_t   ex_o,
  output mem_ctrl_t  mem_o,
  output wb_ctrl_t   wb_o
);
  always_comb begin
    ex_o  = '{reg_dst: 1'b0, alu_src: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    mem_o = '0;
    wb_o  = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ex_o.reg_dst = 1'b1;
        wb_o.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ex_o.alu_op = ALU_ADD;
          FN_SUB:  ex_o.alu_op = ALU_SUB;
          FN_AND:  ex_o.alu_op = ALU_AND;
          FN_OR:   ex_o.alu_op = ALU_OR;
          FN_SLT:  ex_o.alu_op = ALU_SLT;
          default: wb_o.reg_write = 1'b0;
        endcase
      end
      OP_LW: begin
        ex_o.alu_src    = 1'b1;
        mem_o.mem_read  = 1'b1;
        wb_o.reg_write  = 1'b1;
        wb_o.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ex_o.alu_src    = 1'b1;
        mem_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ex_o.branch = 1'b1;
        ex_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs_q [NREG];
  logic         wr_en;

  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wa] <= wd;
    end
  end

  always_comb begin
    if (ra_a == '0)                rd_a = '0;
    else if (wr_en && wa == ra_a)  rd_a = wd;
    else                           rd_a = regs_q[ra_a];
    if (ra_b == '0)                rd_b = '0;
    else if (wr_en && wa == ra_b)  rd_b = wd;
    else                           rd_b = regs_q[ra_b];
  end

  AST_RF_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wa)] == $past(wd))); // R3
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_imem_we,
  input  logic              pl_dmem_we,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [31:0]       pl_data,
  output logic [31:0]       pc_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              st_we_o,
  output logic [31:0]       st_addr_o,
  output logic [31:0]       st_data_o
);
  localparam int MEM_DEPTH = 1 << MEM_AW;

  // reset synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // memories
  logic [XLEN-1:0] imem_q [MEM_DEPTH];
  logic [XLEN-1:0] dmem_q [MEM_DEPTH];

  logic [XLEN-1:0] pc_q, pc_d;
  ifid_t  ifid_q, ifid_d;
  idex_t  idex_q, idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  logic [XLEN-1:0]   pc_plus4, fetch_instr;
  logic [XLEN-1:0]   br_target, alu_b, alu_y;
  logic              alu_zero, br_taken;
  logic [MEM_AW-1:0] dm_idx;
  logic              st_en;
  ex_ctrl_t          dec_ex;
  mem_ctrl_t         dec_mem;
  wb_ctrl_t          dec_wb;
  logic [XLEN-1:0]   rf_a, rf_b, wb_data;
  logic              wb_we;

  always_ff @(posedge clk) begin
    if (pl_imem_we) imem_q[pl_addr] <= pl_data;
  end

  assign dm_idx = exmem_q.alu_y[MEM_AW+1:2];
  assign st_en  = exmem_q.mem.mem_write;

  always_ff @(posedge clk) begin
    if (pl_dmem_we)  dmem_q[pl_addr] <= pl_data;
    else if (st_en)  dmem_q[dm_idx]  <= exmem_q.stdata;
  end

  // fetch
  assign fetch_instr = imem_q[pc_q[MEM_AW+1:2]];
  assign pc_plus4    = pc_q + 32'd4;

  always_comb begin
    pc_d         = br_taken ? br_target : pc_plus4;
    ifid_d.pc4   = pc_plus4;
    ifid_d.instr = fetch_instr;
  end

  // decode
  pipe5_decode u_decode (
    .opcode (ifid_q.instr[31:26]),
    .funct  (ifid_q.instr[5:0]),
    .ex_o   (dec_ex),
    .mem_o  (dec_mem),
    .wb_o   (dec_wb)
  );

  pipe5_regfile #(.W(XLEN), .AW(REG_AW)) u_regfile (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ra_a  (ifid_q.instr[25:21]),
    .ra_b  (ifid_q.instr[20:16]),
    .rd_a  (rf_a),
    .rd_b  (rf_b),
    .we    (wb_we),
    .wa    (memwb_q.dst),
    .wd    (wb_data)
  );

  always_comb begin
    idex_d.ex  = dec_ex;
    idex_d.mem = dec_mem;
    idex_d.wb  = dec_wb;
    idex_d.pc4 = ifid_q.pc4;
    idex_d.opa = rf_a;
    idex_d.opb = rf_b;
    idex_d.imm = {{16{ifid_q.instr[15]}}, ifid_q.instr[15:0]};
    idex_d.rt  = ifid_q.instr[20:16];
    idex_d.rd  = ifid_q.instr[15:11];
  end

  // execute
  assign alu_b = idex_q.ex.alu_src ? idex_q.imm : idex_q.opb;

  pipe5_alu #(.W(XLEN)) u_alu (
    .a    (idex_q.opa),
    .b    (alu_b),
    .op   (idex_q.ex.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
  assign br_taken  = idex_q.ex.branch && alu_zero;

  always_comb begin
    exmem_d.mem    = idex_q.mem;
    exmem_d.wb     = idex_q.wb;
    exmem_d.alu_y  = alu_y;
    exmem_d.stdata = idex_q.opb;
    exmem_d.dst    = idex_q.ex.reg_dst ? idex_q.rd : idex_q.rt;
  end

  // memory
  always_comb begin
    memwb_d.wb    = exmem_q.wb;
    memwb_d.alu_y = exmem_q.alu_y;
    memwb_d.mdata = dmem_q[dm_idx];
    memwb_d.dst   = exmem_q.dst;
  end

  // write-back
  assign wb_data = memwb_q.wb.mem_to_reg ? memwb_q.mdata : memwb_q.alu_y;
  assign wb_we   = memwb_q.wb.reg_write && (memwb_q.dst != '0);

  // pipeline registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = wb_we;
  assign rf_waddr_o = memwb_q.dst;
  assign rf_wdata_o = wb_data;
  assign st_we_o    = st_en;
  assign st_addr_o  = exmem_q.alu_y;
  assign st_data_o  = exmem_q.stdata;

  AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !br_taken |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_taken |=> (pc_q == $past(br_target))); // R6
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exmem_q.mem.mem_write |=> !memwb_q.wb.reg_write); // R5
  AST_LOAD_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exmem_q.mem.mem_read |=> (memwb_q.wb.mem_to_reg && memwb_q.mdata == $past(dmem_q[dm_idx]))); // R4
endmodule

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int NCYC   = 60;
  localparam int NEXP   = NCYC + 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pl_imem_we, pl_dmem_we;
  logic [MEM_AW-1:0] pl_addr;
  logic [31:0]       pl_data;
  logic [31:0]       pc_o, rf_wdata_o, st_addr_o, st_data_o;
  logic              rf_we_o, st_we_o;
  logic [4:0]        rf_waddr_o;

  always #4 clk = ~clk;

  pipe5_core #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pl_imem_we(pl_imem_we), .pl_dmem_we(pl_dmem_we),
    .pl_addr(pl_addr), .pl_data(pl_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .st_we_o(st_we_o),
    .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] mi [DEPTH];
  logic [31:0] md [DEPTH];
  logic [31:0] mr [32];
  int          lastw [32];

  logic        e_we [NEXP];
  logic [4:0]  e_wa [NEXP];
  logic [31:0] e_wd [NEXP];
  string       e_wt [NEXP];
  logic        e_st [NEXP];
  logic [31:0] e_sa [NEXP];
  logic [31:0] e_sd [NEXP];
  string       e_stt [NEXP];
  logic        rv [NEXP];
  logic [31:0] rtg [NEXP];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] mpc;
    bit redir_prev;
    rst_n = 1'b0;
    pl_imem_we = 1'b0; pl_dmem_we = 1'b0; pl_addr = '0; pl_data = '0;

    for (int i = 0; i < DEPTH; i++) begin
      mi[i] = 32'h0;
      md[i] = 32'hA5A5_0000 + i;
    end
    for (int i = 0; i < 32; i++) begin mr[i] = 32'h0; lastw[i] = -100; end
    for (int i = 0; i < NEXP; i++) begin
      e_we[i] = 1'b0; e_wa[i] = '0; e_wd[i] = '0; e_st[i] = 1'b0;
      e_sa[i] = '0; e_sd[i] = '0; rv[i] = 1'b0; rtg[i] = '0;
      e_wt[i] = (i < 4) ? "R1" : "R9";
      e_stt[i] = (i < 4) ? "R1" : "R9";
    end
    md[0] = 32'h0000_0007;
    md[1] = 32'hFFFF_FFF0;
    md[2] = 32'h1234_5678;

    mi[0]  = enc_i(6'h23, 0, 1, 0);
    mi[1]  = enc_i(6'h23, 0, 2, 4);
    mi[2]  = enc_i(6'h23, 0, 3, 8);
    mi[5]  = enc_r(1, 2, 4, 6'h20);
    mi[6]  = enc_r(1, 2, 5, 6'h22);
    mi[7]  = enc_r(3, 2, 6, 6'h24);
    mi[8]  = enc_r(3, 1, 7, 6'h25);
    mi[9]  = enc_r(2, 1, 8, 6'h2A);
    mi[10] = enc_r(1, 2, 9, 6'h2A);
    mi[11] = enc_r(1, 1, 0, 6'h20);
    mi[12] = enc_i(6'h2B, 0, 4, 12);
    mi[13] = enc_i(6'h2B, 0, 3, -4);
    mi[14] = enc_i(6'h23, 0, 10, 12);
    mi[15] = enc_r(0, 1, 11, 6'h20);
    mi[16] = 32'hFC00_0000;
    mi[17] = enc_r(10, 1, 12, 6'h20);
    mi[18] = enc_i(6'h04, 1, 2, 5);
    mi[19] = enc_r(1, 2, 3, 6'h07);
    mi[21] = enc_i(6'h04, 1, 1, 4);
    mi[22] = enc_r(1, 1, 13, 6'h20);
    mi[23] = enc_r(1, 2, 14, 6'h20);
    mi[24] = enc_r(1, 1, 15, 6'h20);
    mi[25] = enc_r(2, 2, 15, 6'h20);
    mi[26] = enc_r(2, 1, 16, 6'h22);
    mi[27] = enc_i(6'h04, 0, 0, -1);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      pl_imem_we = 1'b1; pl_dmem_we = 1'b1;
      pl_addr = i[MEM_AW-1:0];
      pl_data = mi[i];
      @(negedge clk);
      pl_imem_we = 1'b0;
      pl_data = md[i];
    end
    @(negedge clk);
    pl_imem_we = 1'b0; pl_dmem_we = 1'b0;

    // R1: state held in reset
    check(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    check(rf_we_o == 1'b0, "R1", "rf_we in reset", {31'd0, rf_we_o}, 32'h0);
    check(st_we_o == 1'b0, "R1", "st_we in reset", {31'd0, st_we_o}, 32'h0);

    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    mpc = 32'h0;
    redir_prev = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      logic [31:0] ins, va, vb, imm, res, adr;
      logic [5:0]  op, fn;
      int rs, rt, rd;
      bit known, byp;
      string tg;
      @(negedge clk);
      check(pc_o == mpc, (k == 0) ? "R1" : (redir_prev ? "R6" : "R2"), "pc", pc_o, mpc);
      check(rf_we_o == e_we[k], e_wt[k], "rf_we", {31'd0, rf_we_o}, {31'd0, e_we[k]});
      if (e_we[k] && rf_we_o) begin
        check(rf_waddr_o == e_wa[k], e_wt[k], "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, e_wa[k]});
        check(rf_wdata_o == e_wd[k], e_wt[k], "rf_wdata", rf_wdata_o, e_wd[k]);
      end
      check(st_we_o == e_st[k], e_stt[k], "st_we", {31'd0, st_we_o}, {31'd0, e_st[k]});
      if (e_st[k] && st_we_o) begin
        check(st_addr_o == e_sa[k], e_stt[k], "st_addr", st_addr_o, e_sa[k]);
        check(st_data_o == e_sd[k], e_stt[k], "st_data", st_data_o, e_sd[k]);
      end

      // reference model: execute the instruction fetched this cycle
      ins = mi[mpc[MEM_AW+1:2]];
      op  = ins[31:26]; fn = ins[5:0];
      rs  = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      imm = {{16{ins[15]}}, ins[15:0]};
      va  = mr[rs]; vb = mr[rt];
      byp = (rs != 0 && k - lastw[rs] == 3) || (rt != 0 && k - lastw[rt] == 3);
      if (op == 6'h00) begin
        known = 1'b1;
        case (fn)
          6'h20: res = va + vb;
          6'h22: res = va - vb;
          6'h24: res = va & vb;
          6'h25: res = va | vb;
          6'h2A: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
          default: begin known = 1'b0; res = 32'h0; end
        endcase
        if (!known) e_wt[k+4] = "R9";
        else if (rd == 0) e_wt[k+4] = "R7";
        else begin
          tg = byp ? "R8" : ((rs == 0 || rt == 0) ? "R7" : "R3");
          mr[rd] = res; lastw[rd] = k;
          e_we[k+4] = 1'b1; e_wa[k+4] = rd[4:0]; e_wd[k+4] = res; e_wt[k+4] = tg;
        end
      end else if (op == 6'h23) begin
        adr = va + imm;
        res = md[adr[MEM_AW+1:2]];
        if (rt == 0) e_wt[k+4] = "R7";
        else begin
          mr[rt] = res; lastw[rt] = k;
          e_we[k+4] = 1'b1; e_wa[k+4] = rt[4:0]; e_wd[k+4] = res; e_wt[k+4] = "R4";
        end
      end else if (op == 6'h2B) begin
        adr = va + imm;
        md[adr[MEM_AW+1:2]] = vb;
        e_st[k+3] = 1'b1; e_sa[k+3] = adr; e_sd[k+3] = vb; e_stt[k+3] = "R5";
        e_wt[k+4] = "R5";
      end else if (op == 6'h04) begin
        if (va == vb) begin
          rv[k+2]  = 1'b1;
          rtg[k+2] = mpc + 32'd4 + {imm[29:0], 2'b00};
        end
        e_wt[k+4] = "R6";
      end else begin
        e_wt[k+4] = "R9"; e_stt[k+3] = "R9";
      end

      redir_prev = rv[k];
      mpc = rv[k] ? rtg[k] : mpc + 32'd4;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule